// File: doc/BRIEF.md
# Neighbour-Coupling Wire Bundle Self-Test

This block is a built-in self-test engine for a bundle of `W` parallel vertical wires between two dies. It drives test vectors onto the transmit side of the bundle, compares what comes back on the receive side in the same cycle, and collects one sticky fail bit per wire. The vectors detect open wires, shorts between wires, and delay faults in which a wire's transition is held back by a nearby wire that switches the opposite way.

The test relies on a bounded coupling model. A wire can only be disturbed by wires at most `K` positions away. Wires spaced exactly `2K+1` apart are therefore tested as victims together. The bundle is split into `2K+1` interleaved groups, and each group gets a short fixed phase sequence. `K` is chosen at run time when the test starts. A small `K` gives a short in-field test. A larger `K` covers wider coupling. After a start pulse the block runs every group and phase in turn, then pulses `done`. At that point the fail vector holds the result of the whole run.

Top module: `xtalk_wire_bist`

## Requirements
- R1: After reset, `tx_o` is all zeros, `busy` and `done` are low, and `fail_vec` is all zeros.
- R2: An accepted start makes `busy` high for exactly 6*(2K+1) cycles. `done` is then high for exactly one cycle, in the first cycle after `busy` falls.
- R3: The effective order K is taken from `k_sel` in the cycle the start is accepted. A value of 0 is treated as 1, and a value above `KMAX` is treated as `KMAX`. Changing `k_sel` during a run has no effect on that run.
- R4: Groups run in ascending order g = 0 .. 2K. In group g, wire i is a victim when i mod (2K+1) = g, and every other wire is an aggressor. The six phases drive (victim, aggressor) levels in this order: (0,1), (1,0), (0,1), (0,0), (1,0), (0,0).
- R5: During a run, `fail_vec[i]` is set in any cycle where `rx_i[i]` differs from `tx_o[i]`. Once set, it stays set for the rest of the run and after it. It is cleared only when a start is accepted.
- R6: A start that arrives while `busy` is high is ignored: the run length and the pattern are unchanged.
- R7: While `busy` is low, `tx_o` is all zeros, and mismatches on `rx_i` do not change `fail_vec`.
- R8: A delay fault is flagged when a wire's transition is held back by a wire within distance K that switches the opposite way. Wires exactly 2K+1 apart always drive equal values, so coupling at that distance is never provoked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a test run when the block is idle |
| k_sel | input | $clog2(KMAX+1) | Requested aggressor order |
| rx_i | input | W | Values received from the far end of the bundle |
| tx_o | output | W | Test values driven into the bundle |
| busy | output | 1 | High while the test sequence runs |
| done | output | 1 | One-cycle pulse when a run completes |
| fail_vec | output | W | Sticky per-wire fail flags |

## Verification
Two events can land in the same cycle: the completion pulse of one run and the acceptance of the next start. Together they decide whether the fail flags that were just reported are cleared or kept. The bench faults a wire, runs a test, and raises `start` with a new `k_sel` in exactly the cycle where `done` is seen high. It then expects `busy` high, `fail_vec` cleared in the next cycle, and the new run to take the length implied by the new order. The bench also injects a coupling fault at distance 3. It expects that fault to go unseen with order 1 and to be flagged with order 2.

// File: rtl/agb_pkg.sv
package agb_pkg;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

  localparam int PHASES = 6;
  // level driven per phase, bit index = phase number
  localparam logic [7:0] VICTIM_LVL = 8'b0001_0010;
  localparam logic [7:0] AGGR_LVL   = 8'b0000_0101;

  function automatic int unsigned eff_order(int unsigned ksel, int unsigned kmax);
    if (ksel == 0) return 1;
    if (ksel > kmax) return kmax;
    return ksel;
  endfunction

  function automatic int unsigned group_count(int unsigned k);
    return 2 * k + 1;
  endfunction

  function automatic logic is_victim(int unsigned idx, int unsigned per, int unsigned grp);
    return (idx % per) == grp;
  endfunction

  function automatic logic drive_level(logic [2:0] ph, logic vic);
    return vic ? VICTIM_LVL[ph] : AGGR_LVL[ph];
  endfunction

endpackage

// File: rtl/agb_seq.sv
module agb_seq
  import agb_pkg::*;
#(
  parameter int KMAX = 3,
  localparam int KW = $clog2(KMAX + 1),
  localparam int GW = $clog2(2 * KMAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] k_sel,
  output logic          busy,
  output logic          done,
  output logic          accept,
  output logic [GW-1:0] grp,
  output logic [2:0]    phase,
  output logic [GW-1:0] period
);

  seq_state_e    state;
  logic [KW-1:0] k_q;
  logic          last_phase, last_grp, run_end;

  assign busy       = (state == SEQ_RUN);
  assign accept     = (state == SEQ_IDLE) && start;
  assign period     = GW'(group_count(32'(k_q)));
  assign last_phase = (phase == 3'(PHASES - 1));
  assign last_grp   = (grp == period - 1'b1);
  assign run_end    = busy && last_phase && last_grp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      k_q   <= KW'(1);
      grp   <= '0;
      phase <= '0;
      done  <= 1'b0;
    end else begin
      done <= run_end;
      if (accept) begin
        state <= SEQ_RUN;
        k_q   <= KW'(eff_order(32'(k_sel), KMAX));
        grp   <= '0;
        phase <= '0;
      end else if (busy) begin
        if (last_phase) begin
          phase <= '0;
          if (last_grp) begin
            state <= SEQ_IDLE;
            grp   <= '0;
          end else begin
            grp <= grp + 1'b1;
          end
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R2
  AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(k_q)); // R3
  AST_ORDER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    k_q != '0); // R3
  AST_GROUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (grp < period && phase < 3'(PHASES))); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !run_end) |=> (busy && $stable(k_q))); // R6

endmodule

// File: rtl/agb_pattern.sv
module agb_pattern
  import agb_pkg::*;
#(
  parameter int W  = 16,
  parameter int GW = 3
) (
  input  logic          busy,
  input  logic [GW-1:0] grp,
  input  logic [2:0]    phase,
  input  logic [GW-1:0] period,
  output logic [W-1:0]  tx
);

  logic [W-1:0] vic_mask;

  for (genvar i = 0; i < W; i++) begin : g_wire
    assign vic_mask[i] = is_victim(32'(i), 32'(period), 32'(grp));
    assign tx[i]       = busy & drive_level(phase, vic_mask[i]);
  end

endmodule

// File: rtl/agb_fail_acc.sv
module agb_fail_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         en,
  input  logic [W-1:0] tx,
  input  logic [W-1:0] rx,
  output logic [W-1:0] fail
);

  logic [W-1:0] miss;
  assign miss = tx ^ rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fail <= '0;
    else if (clear)  fail <= '0;
    else if (en)     fail <= fail | miss;
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ((fail & $past(fail)) == $past(fail))); // R5
  AST_FAIL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fail == '0)); // R5
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clear) |=> $stable(fail)); // R7

endmodule

// File: rtl/xtalk_wire_bist.sv
module xtalk_wire_bist #(
  parameter int W    = 16,
  parameter int KMAX = 3,
  localparam int KW  = $clog2(KMAX + 1),
  localparam int GW  = $clog2(2 * KMAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] k_sel,
  input  logic [W-1:0]  rx_i,
  output logic [W-1:0]  tx_o,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  fail_vec
);

  logic          accept;
  logic [GW-1:0] grp, period;
  logic [2:0]    phase;

  agb_seq #(.KMAX(KMAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .k_sel(k_sel),
    .busy(busy), .done(done), .accept(accept),
    .grp(grp), .phase(phase), .period(period)
  );

  agb_pattern #(.W(W), .GW(GW)) u_pat (
    .busy(busy), .grp(grp), .phase(phase), .period(period), .tx(tx_o)
  );

  agb_fail_acc #(.W(W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept), .en(busy),
    .tx(tx_o), .rx(rx_i), .fail(fail_vec)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_o == '0)); // R7

endmodule

// File: tb/xtalk_wire_bist_test.sv
module xtalk_wire_bist_test;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]   k_sel = 2'd1;
  logic [W-1:0] rx, tx_o, fail_vec, prv;
  logic busy, done;

  int nvec = 0, nfail = 0;
  bit open_en = 0, short_en = 0, dly_en = 0;
  int open_w = 0, sh_a = 0, sh_b = 0, dly_w = 0, dly_d = 1, clear_at = -1;
  logic opp;

  always #10 clk = ~clk;

  xtalk_wire_bist #(.W(W), .KMAX(3)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .k_sel(k_sel), .rx_i(rx),
    .tx_o(tx_o), .busy(busy), .done(done), .fail_vec(fail_vec)
  );

  always @(posedge clk) prv <= tx_o;

  // faulty bundle model
  always_comb begin
    rx  = tx_o;
    opp = 1'b0;
    if (dly_en) begin
      if (dly_w + dly_d < W)
        opp = opp | ((tx_o[dly_w+dly_d] != prv[dly_w+dly_d]) && (tx_o[dly_w+dly_d] != tx_o[dly_w]));
      if (dly_w - dly_d >= 0)
        opp = opp | ((tx_o[dly_w-dly_d] != prv[dly_w-dly_d]) && (tx_o[dly_w-dly_d] != tx_o[dly_w]));
      if (opp && (tx_o[dly_w] != prv[dly_w])) rx[dly_w] = prv[dly_w];
    end
    if (short_en) begin
      rx[sh_a] = tx_o[sh_a] & tx_o[sh_b];
      rx[sh_b] = tx_o[sh_a] & tx_o[sh_b];
    end
    if (open_en) rx[open_w] = 1'b0;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_tx(int idx, int k);
    int per = 2 * k + 1;
    int g = idx / 6;
    logic vl, al;
    logic [W-1:0] v;
    case (idx % 6)
      0: begin vl = 0; al = 1; end
      1: begin vl = 1; al = 0; end
      2: begin vl = 0; al = 1; end
      4: begin vl = 1; al = 0; end
      default: begin vl = 0; al = 0; end
    endcase
    for (int i = 0; i < W; i++) v[i] = ((i % per) == g) ? vl : al;
    return v;
  endfunction

  // one run; pattern checked every busy cycle (R4), done pulse checked (R2)
  task automatic run_bist(input int kin, input int keff, input bit poke_start,
                          input bit poke_k, input bit pre_started);
    int len = 0, perr = 0;
    if (!pre_started) begin
      @(negedge clk); k_sel = 2'(kin); start = 1'b1;
    end
    @(negedge clk); start = 1'b0;
    while (busy && len < 1000) begin
      if (tx_o !== exp_tx(len, keff)) perr++;
      start = (poke_start && len == 5);
      if (poke_k && len == 4) k_sel = (kin == 3) ? 2'd1 : 2'd3;
      if (len == clear_at) open_en = 0;
      len++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done === 1'b1, "R2 done pulse", 32'(done), 1);
    chk(len == 6 * (2 * keff + 1), "R2/R3/R6 run length", len, 6 * (2 * keff + 1));
    chk(perr == 0, "R4 pattern", perr, 0);
    @(negedge clk);
    chk(done === 1'b0, "R2 done single", 32'(done), 0);
  endtask

  task automatic t_reset();
    chk(tx_o == '0 && !busy && !done && fail_vec == '0, "R1 reset state",
        {busy, done, 14'h0, tx_o}, 0);
  endtask

  task automatic t_clean();
    run_bist(1, 1, 0, 0, 0);
    chk(fail_vec == '0, "R5 clean K=1", fail_vec, 0);
    run_bist(3, 3, 0, 0, 0);
    chk(fail_vec == '0, "R5 clean K=3", fail_vec, 0);
    run_bist(0, 1, 0, 0, 0); // R3 zero maps to one
  endtask

  task automatic t_open_short();
    open_en = 1; open_w = 5;
    run_bist(2, 2, 0, 0, 0);
    chk(fail_vec == 16'h0020, "R5 open wire", fail_vec, 16'h0020);
    open_en = 0; short_en = 1; sh_a = 3; sh_b = 4;
    run_bist(1, 1, 0, 0, 0);
    chk(fail_vec == 16'h0018, "R5 short pair", fail_vec, 16'h0018);
    short_en = 0;
  endtask

  task automatic t_sticky_idle();
    open_en = 1; open_w = 1; clear_at = 8;
    run_bist(1, 1, 0, 0, 0);
    clear_at = -1;
    chk(fail_vec == 16'h0002, "R5 sticky", fail_vec, 16'h0002);
    run_bist(1, 1, 0, 0, 0);
    chk(fail_vec == 16'h0000, "R5 cleared at start", fail_vec, 0);
    open_en = 1; open_w = 9;
    repeat (10) @(negedge clk);
    chk(fail_vec == '0 && tx_o == '0, "R7 idle ignored", fail_vec, 0);
    open_en = 0;
  endtask

  task automatic t_ignore();
    run_bist(2, 2, 1, 0, 0); // R6 start while busy
    run_bist(3, 3, 0, 1, 0); // R3 k_sel change mid-run
  endtask

  task automatic t_delay();
    dly_en = 1; dly_w = 8; dly_d = 1;
    run_bist(1, 1, 0, 0, 0);
    chk(fail_vec == 16'h0100, "R8 adjacent coupling", fail_vec, 16'h0100);
    dly_d = 3;
    run_bist(1, 1, 0, 0, 0);
    chk(fail_vec == 16'h0000, "R8 distance 2K+1 unprovoked", fail_vec, 0);
    run_bist(2, 2, 0, 0, 0);
    chk(fail_vec == 16'h0100, "R8 distance 3 with K=2", fail_vec, 16'h0100);
    dly_en = 0;
  endtask

  // done and a new start in the same cycle
  task automatic t_back_to_back();
    int n = 0;
    open_en = 1; open_w = 12;
    @(negedge clk); k_sel = 2'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && n < 1000) begin n++; @(negedge clk); end
    chk(fail_vec == 16'h1000, "R5 before restart", fail_vec, 16'h1000);
    open_en = 0; k_sel = 2'd2; start = 1'b1;
    run_bist(2, 2, 0, 0, 1);
    chk(fail_vec == '0, "R5 restart at done clears", fail_vec, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_open_short();
    t_sticky_idle();
    t_ignore();
    t_delay();
    t_back_to_back();
    summary();
    $finish;
  end
endmodule